// File: doc/BRIEF.md
# Seed-Injected Scan Decompressor

This block turns a narrow stream of seed bits from a tester into parallel stimulus for many scan chains. A 32-stage ring register runs in Galois form: its last stage loops back to stage 0 and is also XORed into a few interior stages, so no feedback net has to cross the whole register. On every enabled shift, two seed inputs are XORed into the register at evenly spaced stages. A phase shifter made only of XOR gates forms each chain's input from three register stages.

Each scan pattern starts with a clear of the register. The tester then streams seed bits while the chains shift. Every chain bit is a linear (GF(2)) function of the injected bits. Software can therefore solve for the seeds that place the required care bits. All other positions are filled with pseudo-random data. This only works while the number of care bits per pattern stays well below the number of injected bits.

Top module: `seed_decomp`

## Requirements
- R1: While `rst_n` is low the register is cleared, so every chain output is 0 on the first sample after reset.
- R2: `init_i` high clears the register to all zeros at the next clock edge, whatever `shift_en_i` and `seed_i` are.
- R3: With `init_i` low and `shift_en_i` low, the register holds its value and every chain output stays unchanged for any `seed_i`.
- R4: On an enabled shift (`init_i` low, `shift_en_i` high), next stage i equals stage i-1 for i>0, and next stage 0 equals stage 31. Stage 31 is additionally XORed into next stages 1, 2 and 22.
- R5: On an enabled shift, `seed_i[0]` is XORed into next stage 0 and `seed_i[1]` is XORed into next stage 16.
- R6: `chain_o[c]` is combinational from the register: the XOR of stages c, (3c+17) mod 32 and (5c+10) mod 32. The three stages are distinct and no two chains share a tap set. Starting from a cleared register, one shift with `seed_i`=01 gives `chain_o`=16'h0021.
- R7: The block is linear. From a cleared register, the outputs produced by seed stream A XOR seed stream B equal the XOR of the outputs from A alone and from B alone.
- R8: From a cleared register, shifting with `seed_i`=0 keeps every chain output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Clear the register before a pattern |
| shift_en_i | input | 1 | Advance the register and take in seed bits |
| seed_i | input | 2 | Seed bits injected at stages 0 and 16 |
| chain_o | output | 16 | Scan-chain input bits, one per chain |

## Verification
The register is the only flop on any path, so a change in `init_i`, `shift_en_i` or `seed_i` reaches `chain_o` one clock edge later. The chain outputs themselves follow the register with no further delay. The bench drives every input on the falling edge and checks `chain_o` on the next falling edge, after exactly one rising edge. At that point it compares against a bench model that it advances once per edge. The linearity check runs three full 40-shift patterns and compares only the outputs captured after the last shift of each pattern.

// File: rtl/sdc_pkg.sv
// Shared helpers for the seed decompressor.
// Assumes chain index and register width are small positive integers.
package sdc_pkg;

    // Tap k (0..2) of a chain: the stage that feeds its XOR.
    function automatic int tap_pos(input int chain, input int k, input int regw);
        case (k)
            0:       return chain % regw;
            1:       return (3 * chain + 17) % regw;
            default: return (5 * chain + 10) % regw;
        endcase
    endfunction

endpackage

// File: rtl/sdc_inject.sv
// Spreads the seed bits into a register-wide XOR vector, one seed bit per
// evenly spaced stage. Assumes INJ_W divides REG_W.
module sdc_inject #(
    parameter int REG_W = 32,
    parameter int INJ_W = 2
) (
    input  logic [INJ_W-1:0] seed_i,
    output logic [REG_W-1:0] inj_vec_o
);
    localparam int STEP = REG_W / INJ_W;

    // Place each seed bit at its injection stage; zeros elsewhere.
    always_comb begin
        inj_vec_o = '0;
        for (int j = 0; j < INJ_W; j++) begin
            inj_vec_o[j*STEP] = seed_i[j];
        end
    end
endmodule

// File: rtl/sdc_ring.sv
// Galois ring register: the last stage rotates into stage 0 and is XORed
// into the stages in FB_MASK, with the injection vector XORed in on
// every enabled shift. Assumes FB_MASK bit 0 is zero.
module sdc_ring #(
    parameter int               REG_W   = 32,
    parameter logic [REG_W-1:0] FB_MASK = 32'h0040_0006
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             shift_en_i,
    input  logic [REG_W-1:0] inj_vec_i,
    output logic [REG_W-1:0] state_o
);
    logic [REG_W-1:0] state_q;
    logic [REG_W-1:0] next_s;
    logic             fb;

    // Linear next-state: rotate, fold last stage back, add seeds.
    always_comb begin
        fb     = state_q[REG_W-1];
        next_s = {state_q[REG_W-2:0], fb} ^ (FB_MASK & {REG_W{fb}}) ^ inj_vec_i;
    end

    // Register update: reset and init clear, enable advances.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= '0;
        else if (init_i)     state_q <= '0;
        else if (shift_en_i) state_q <= next_s;
    end

    assign state_o = state_q;
endmodule

// File: rtl/sdc_phase.sv
// Phase shifter: each chain output is the XOR of three register stages
// chosen by sdc_pkg::tap_pos. Assumes CHAINS <= REG_W.
module sdc_phase #(
    parameter int REG_W  = 32,
    parameter int CHAINS = 16
) (
    input  logic [REG_W-1:0]  state_i,
    output logic [CHAINS-1:0] chain_o
);
    for (genvar c = 0; c < CHAINS; c++) begin : g_chain
        localparam int TA = sdc_pkg::tap_pos(c, 0, REG_W);
        localparam int TB = sdc_pkg::tap_pos(c, 1, REG_W);
        localparam int TC = sdc_pkg::tap_pos(c, 2, REG_W);
        // Three-input XOR for chain c.
        assign chain_o[c] = state_i[TA] ^ state_i[TB] ^ state_i[TC];
    end
endmodule

// File: rtl/seed_decomp.sv
// Seed-injected scan decompressor top. XOR gates and flops only, so the
// chain outputs are linear in the injected seed bits.
// Assumes the tester pulses init_i before each pattern.
module seed_decomp #(
    parameter int               REG_W   = 32,
    parameter int               INJ_W   = 2,
    parameter int               CHAINS  = 16,
    parameter logic [REG_W-1:0] FB_MASK = 32'h0040_0006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              shift_en_i,
    input  logic [INJ_W-1:0]  seed_i,
    output logic [CHAINS-1:0] chain_o
);
    logic [REG_W-1:0] inj_vec;
    logic [REG_W-1:0] state_q;

    sdc_inject #(.REG_W(REG_W), .INJ_W(INJ_W)) u_inject (
        .seed_i   (seed_i),
        .inj_vec_o(inj_vec)
    );

    sdc_ring #(.REG_W(REG_W), .FB_MASK(FB_MASK)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .shift_en_i(shift_en_i),
        .inj_vec_i (inj_vec),
        .state_o   (state_q)
    );

    sdc_phase #(.REG_W(REG_W), .CHAINS(CHAINS)) u_phase (
        .state_i(state_q),
        .chain_o(chain_o)
    );
endmodule

// File: rtl/sdc_checker.sv
// Temporal checks on the decompressor, bound into every instance of the top.
module sdc_checker #(
    parameter int REG_W  = 32,
    parameter int INJ_W  = 2,
    parameter int CHAINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              shift_en_i,
    input logic [INJ_W-1:0]  seed_i,
    input logic [REG_W-1:0]  state_q,
    input logic [CHAINS-1:0] chain_o
);
    localparam int STEP = REG_W / INJ_W;

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (state_q == '0)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !shift_en_i) |=> $stable(chain_o)); // R3

    AST_SEED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && shift_en_i) |=> (state_q[0] == ($past(state_q[REG_W-1]) ^ $past(seed_i[0])))); // R5

    AST_SEED_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && shift_en_i) |=> (state_q[STEP] == ($past(state_q[STEP-1]) ^ $past(seed_i[1])))); // R5

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0) |-> (chain_o == '0)); // R6

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0 && seed_i == '0 && !init_i) |=> (chain_o == '0)); // R8
endmodule

bind seed_decomp sdc_checker #(.REG_W(REG_W), .INJ_W(INJ_W), .CHAINS(CHAINS)) u_sdc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_i),
    .shift_en_i(shift_en_i),
    .seed_i    (seed_i),
    .state_q   (state_q),
    .chain_o   (chain_o)
);

// File: tb/seed_decomp_test.sv
// Bench for seed_decomp: table-driven walk against a model built from the
// requirements, then directed checks for reset, init, hold and linearity.
module seed_decomp_test;
    localparam int W = 32;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic         shift_en_i = 1'b0;
    logic [1:0]   seed_i = 2'b00;
    logic [N-1:0] chain_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_s = '0;

    seed_decomp uut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .shift_en_i(shift_en_i), .seed_i(seed_i), .chain_o(chain_o)
    );

    always #2 clk = ~clk;

    // Stimulus table: {init, shift_en, seed[1:0]}.
    localparam logic [3:0] VEC [0:19] = '{
        4'b1000, 4'b0101, 4'b0100, 4'b0110, 4'b0111, 4'b0001,
        4'b0110, 4'b0100, 4'b0101, 4'b0011, 4'b0111, 4'b0100,
        4'b1111, 4'b0110, 4'b0101, 4'b0101, 4'b0010, 4'b0111,
        4'b0100, 4'b0110
    };

    // Next state from R4 and R5.
    function automatic logic [W-1:0] m_next(input logic [W-1:0] s, input logic [1:0] d);
        logic [W-1:0] n;
        n = {s[W-2:0], s[W-1]};
        n[1]  ^= s[W-1];
        n[2]  ^= s[W-1];
        n[22] ^= s[W-1];
        n[0]  ^= d[0];
        n[16] ^= d[1];
        return n;
    endfunction

    // Chain outputs from R6.
    function automatic logic [N-1:0] m_out(input logic [W-1:0] s);
        logic [N-1:0] o;
        for (int c = 0; c < N; c++)
            o[c] = s[c % W] ^ s[(3*c+17) % W] ^ s[(5*c+10) % W];
        return o;
    endfunction

    function automatic logic [1:0] seed_of(input logic [31:0] key, input int k);
        return {key[(k+7) % 32], key[k % 32]};
    endfunction

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: chain_o=%h expected %h", req, got, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, sample at next negedge.
    task automatic step(input logic i, input logic sh, input logic [1:0] d);
        init_i = i; shift_en_i = sh; seed_i = d;
        @(posedge clk);
        if (!rst_n)   m_s = '0;
        else if (i)   m_s = '0;
        else if (sh)  m_s = m_next(m_s, d);
        @(negedge clk);
    endtask

    task automatic run_pattern(input logic [31:0] key, output logic [N-1:0] res);
        step(1'b1, 1'b0, 2'b00);
        for (int k = 0; k < 40; k++) step(1'b0, 1'b1, seed_of(key, k));
        res = chain_o;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] ra, rb, rab, held;
        @(negedge clk);
        step(1'b0, 1'b1, 2'b11);
        step(1'b0, 1'b1, 2'b01);
        check("R1 reset", chain_o, '0);
        rst_n = 1'b1;

        // R4 R5 R6 table walk against the model.
        for (int v = 0; v < 20; v++) begin
            step(VEC[v][3], VEC[v][2], VEC[v][1:0]);
            check("R4 R5 table", chain_o, m_out(m_s));
        end

        // R6 single seed bit from cleared register.
        step(1'b1, 1'b0, 2'b00);
        step(1'b0, 1'b1, 2'b01);
        check("R6 single seed", chain_o, 16'h0021);

        // R5 upper seed bit only, then long run to reach feedback (R4).
        step(1'b1, 1'b0, 2'b00);
        step(1'b0, 1'b1, 2'b10);
        check("R5 upper seed", chain_o, m_out(m_s));
        for (int k = 0; k < 40; k++) step(1'b0, 1'b1, 2'b00);
        check("R4 feedback wrap", chain_o, m_out(m_s));

        // R3 hold while seeds toggle.
        held = chain_o;
        step(1'b0, 1'b0, 2'b11);
        step(1'b0, 1'b0, 2'b10);
        check("R3 hold", chain_o, held);
        step(1'b0, 1'b0, 2'b01);
        check("R3 hold", chain_o, held);

        // R2 init beats shift and seeds.
        step(1'b1, 1'b1, 2'b11);
        check("R2 init priority", chain_o, '0);

        // R8 zero seeds keep zero output.
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 2'b00);
        check("R8 zero stays", chain_o, '0);

        // R7 superposition of two seed streams.
        run_pattern(32'h9E37_79B9, ra);
        check("R7 pattern A", ra, m_out(m_s));
        run_pattern(32'h5A5A_C3F1, rb);
        check("R7 pattern B", rb, m_out(m_s));
        run_pattern(32'h9E37_79B9 ^ 32'h5A5A_C3F1, rab);
        check("R7 linearity", rab, ra ^ rb);

        // R1 reset during a run.
        rst_n = 1'b0;
        step(1'b0, 1'b1, 2'b11);
        check("R1 mid-run reset", chain_o, '0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 2'b01);
        check("R6 after reset", chain_o, 16'h0021);

        finish_run();
    end
endmodule